// File: doc/BRIEF.md
# Conditional 16-bit logic unit

This block is the execute stage for bitwise logic instructions in a processor whose general registers are 24 bits wide. Each cycle it can accept one operation: OR, XOR or NOT. The operation works on the low 16 bits of the destination register value and a second operand.

The second operand can come from three places: a source register value, a 7-bit immediate that is sign-extended to 16 bits, or a full 16-bit immediate. Each operation can run unconditionally, or only when the incoming carry flag has a given value. When the condition fails, the instruction does nothing.

The result, a write-enable and the updated condition flags are registered, so they appear one cycle after the inputs. Every executed result has its top eight bits cleared. A skipped instruction produces no write. It also returns the incoming destination value and the incoming flags unchanged.

Top module: `cond_logic_unit`

## Requirements
- R1: When `wr_en` is 1, `rd_new[23:16]` is zero. This holds for every operation, operand source and condition mode.
- R2: Operation code `op_sel=2'b00` (OR) gives `rd_new[15:0] = rd_val[15:0] | operand`.
- R3: Operation code `op_sel=2'b01` (XOR) gives `rd_new[15:0] = rd_val[15:0] ^ operand`.
- R4: Operation code `op_sel=2'b10` (NOT) gives `rd_new[15:0] = ~operand`. The old value of `rd_val` has no effect on the result.
- R5: Condition code `cond_sel=2'b01` executes only when `flag_c` is 1. When `flag_c` is 0, the instruction is skipped. Condition code `2'b00` always executes.
- R6: Condition code `cond_sel=2'b10` executes only when `flag_c` is 0. When `flag_c` is 1, the instruction is skipped.
- R7: The operand source is chosen by `src_sel`:
  - `2'b00` takes `rs_val[15:0]`.
  - `2'b01` takes `imm7` sign-extended from its bit 6 to 16 bits.
  - `2'b10` takes `imm16` unchanged.
- R8: An executed operation drives `v_out` to 0.
- R9: An executed operation sets `z_out` when `rd_new[15:0]` is zero and copies `rd_new[15]` to `n_out`. `c_out` always equals the incoming `flag_c`.
- R10: A skipped instruction gives `wr_en=0`, `rd_new=rd_val`, and `v_out`, `z_out`, `n_out` equal to the incoming flags.
- R11: Any reserved code is treated as a skipped instruction. The reserved codes are `op_sel=2'b11`, `cond_sel=2'b11` and `src_sel=2'b11`.
- R12: All outputs are registered with one cycle of latency. `out_valid` follows `in_valid`, and `wr_en` is 0 whenever `in_valid` was 0.
- R13: A synchronous active-high `rst` drives every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented this cycle |
| op_sel | input | 2 | Operation: 00 OR, 01 XOR, 10 NOT |
| cond_sel | input | 2 | Condition: 00 always, 01 carry set, 10 carry clear |
| src_sel | input | 2 | Operand source: 00 register, 01 signed 7-bit immediate, 10 16-bit immediate |
| rd_val | input | 24 | Current destination register value |
| rs_val | input | 24 | Source register value |
| imm7 | input | 7 | Short signed immediate |
| imm16 | input | 16 | Long immediate |
| flag_c | input | 1 | Incoming carry flag |
| flag_v | input | 1 | Incoming overflow flag |
| flag_z | input | 1 | Incoming zero flag |
| flag_n | input | 1 | Incoming negative flag |
| out_valid | output | 1 | Registered copy of in_valid |
| wr_en | output | 1 | Write the destination register |
| rd_new | output | 24 | New destination value |
| c_out | output | 1 | Carry flag after the instruction |
| v_out | output | 1 | Overflow flag after the instruction |
| z_out | output | 1 | Zero flag after the instruction |
| n_out | output | 1 | Negative flag after the instruction |

## Verification
Each operation is driven with destination and source values whose upper bytes are nonzero. This shows whether the clearing of bits 23:16 and the masking of the source's upper byte are both in place. The immediate vectors use one 7-bit value with bit 6 set and one with bit 6 clear, which separates sign extension from zero extension. A NOT on a destination full of ones shows whether the old value leaks into the result. Each conditional mode is run with both carry values, and each reserved code is run once. The skipped cases return a distinctive destination value and incoming flag pattern, so a spurious write or flag change shows at the ports.

// File: rtl/clu_pkg.sv
package clu_pkg;
  typedef enum logic [1:0] {
    OP_OR  = 2'b00,
    OP_XOR = 2'b01,
    OP_NOT = 2'b10,
    OP_RSV = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    CND_ALWAYS = 2'b00,
    CND_CSET   = 2'b01,
    CND_CCLR   = 2'b10,
    CND_RSV    = 2'b11
  } cond_e;

  typedef enum logic [1:0] {
    SRC_REG  = 2'b00,
    SRC_SIMM = 2'b01,
    SRC_LIMM = 2'b10,
    SRC_RSV  = 2'b11
  } src_e;
endpackage

// File: rtl/clu_operand_mux.sv
module clu_operand_mux
  import clu_pkg::*;
#(
  parameter int REG_W  = 24,
  parameter int DATA_W = 16,
  parameter int SIMM_W = 7
) (
  input  logic [1:0]        src_sel,
  input  logic [REG_W-1:0]  rs_val,
  input  logic [SIMM_W-1:0] imm7,
  input  logic [DATA_W-1:0] imm16,
  output logic [DATA_W-1:0] operand,
  output logic              src_ok
);
  localparam int EXT_W = DATA_W - SIMM_W;

  logic [DATA_W-1:0] simm_ext;
  logic              unused_rs_hi;

  assign unused_rs_hi = ^rs_val[REG_W-1:DATA_W];

  // Replicate the sign bit into every upper position.
  generate
    for (genvar g = 0; g < DATA_W; g++) begin : g_sext
      if (g < SIMM_W) begin : g_low
        assign simm_ext[g] = imm7[g];
      end else begin : g_high
        assign simm_ext[g] = imm7[SIMM_W-1];
      end
    end
  endgenerate

  always_comb begin
    operand = '0;
    src_ok  = 1'b1;
    case (src_e'(src_sel))
      SRC_REG:  operand = rs_val[DATA_W-1:0];
      SRC_SIMM: operand = simm_ext;
      SRC_LIMM: operand = imm16;
      default:  src_ok  = 1'b0;
    endcase
  end

  initial begin
    if (EXT_W < 0) $error("short immediate wider than data path");
  end
endmodule

// File: rtl/clu_logic_core.sv
module clu_logic_core
  import clu_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [1:0]        op_sel,
  input  logic [DATA_W-1:0] dst_lo,
  input  logic [DATA_W-1:0] operand,
  output logic [DATA_W-1:0] result,
  output logic              op_ok,
  output logic              res_zero,
  output logic              res_neg
);
  always_comb begin
    result = '0;
    op_ok  = 1'b1;
    case (op_e'(op_sel))
      OP_OR:   result = dst_lo | operand;
      OP_XOR:  result = dst_lo ^ operand;
      OP_NOT:  result = ~operand;
      default: op_ok  = 1'b0;
    endcase
  end

  assign res_zero = ~|result;
  assign res_neg  = result[DATA_W-1];
endmodule

// File: rtl/clu_cond_eval.sv
module clu_cond_eval
  import clu_pkg::*;
(
  input  logic [1:0] cond_sel,
  input  logic       flag_c,
  output logic       cond_pass
);
  always_comb begin
    case (cond_e'(cond_sel))
      CND_ALWAYS: cond_pass = 1'b1;
      CND_CSET:   cond_pass = flag_c;
      CND_CCLR:   cond_pass = ~flag_c;
      default:    cond_pass = 1'b0;
    endcase
  end
endmodule

// File: rtl/cond_logic_unit.sv
module cond_logic_unit #(
  parameter int REG_W  = 24,
  parameter int DATA_W = 16,
  parameter int SIMM_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op_sel,
  input  logic [1:0]        cond_sel,
  input  logic [1:0]        src_sel,
  input  logic [REG_W-1:0]  rd_val,
  input  logic [REG_W-1:0]  rs_val,
  input  logic [SIMM_W-1:0] imm7,
  input  logic [DATA_W-1:0] imm16,
  input  logic              flag_c,
  input  logic              flag_v,
  input  logic              flag_z,
  input  logic              flag_n,
  output logic              out_valid,
  output logic              wr_en,
  output logic [REG_W-1:0]  rd_new,
  output logic              c_out,
  output logic              v_out,
  output logic              z_out,
  output logic              n_out
);
  localparam int HI_W = REG_W - DATA_W;

  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] result;
  logic              src_ok, op_ok, cond_pass;
  logic              res_zero, res_neg;
  logic              exec;
  logic [REG_W-1:0]  next_rd;

  clu_operand_mux #(.REG_W(REG_W), .DATA_W(DATA_W), .SIMM_W(SIMM_W)) u_opnd (
    .src_sel (src_sel),
    .rs_val  (rs_val),
    .imm7    (imm7),
    .imm16   (imm16),
    .operand (operand),
    .src_ok  (src_ok)
  );

  clu_logic_core #(.DATA_W(DATA_W)) u_core (
    .op_sel   (op_sel),
    .dst_lo   (rd_val[DATA_W-1:0]),
    .operand  (operand),
    .result   (result),
    .op_ok    (op_ok),
    .res_zero (res_zero),
    .res_neg  (res_neg)
  );

  clu_cond_eval u_cond (
    .cond_sel  (cond_sel),
    .flag_c    (flag_c),
    .cond_pass (cond_pass)
  );

  assign exec    = in_valid & src_ok & op_ok & cond_pass;
  assign next_rd = exec ? {{HI_W{1'b0}}, result} : rd_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      rd_new    <= '0;
      c_out     <= 1'b0;
      v_out     <= 1'b0;
      z_out     <= 1'b0;
      n_out     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= exec;
      rd_new    <= next_rd;
      c_out     <= flag_c;
      v_out     <= exec ? 1'b0     : flag_v;
      z_out     <= exec ? res_zero : flag_z;
      n_out     <= exec ? res_neg  : flag_n;
    end
  end
endmodule

// File: rtl/clu_checker.sv
module clu_checker #(
  parameter int REG_W  = 24,
  parameter int DATA_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [1:0]       cond_sel,
  input logic             flag_c,
  input logic             flag_v,
  input logic             flag_z,
  input logic             flag_n,
  input logic             out_valid,
  input logic             wr_en,
  input logic [REG_W-1:0] rd_new,
  input logic             c_out,
  input logic             v_out,
  input logic             z_out,
  input logic             n_out
);
  AST_UPPER_CLEAR: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> rd_new[REG_W-1:DATA_W] == '0); // R1
  AST_CSET_SKIP: assert property (@(posedge clk) disable iff (rst)
    ($past(cond_sel) == 2'b01 && !$past(flag_c)) |-> !wr_en); // R5
  AST_CCLR_SKIP: assert property (@(posedge clk) disable iff (rst)
    ($past(cond_sel) == 2'b10 && $past(flag_c)) |-> !wr_en); // R6
  AST_V_CLEARED: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !v_out); // R8
  AST_Z_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (z_out == (rd_new[DATA_W-1:0] == '0))); // R9
  AST_N_FROM_RESULT: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (n_out == rd_new[DATA_W-1])); // R9
  AST_C_KEPT: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (c_out == $past(flag_c))); // R9
  AST_SKIP_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !wr_en) |-> (v_out == $past(flag_v) && z_out == $past(flag_z)
                               && n_out == $past(flag_n))); // R10
  AST_WE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> out_valid); // R12
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    out_valid == $past(in_valid)); // R12
endmodule

bind cond_logic_unit clu_checker #(.REG_W(REG_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/cond_logic_unit_bench.sv
module cond_logic_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 16;
  localparam int WATCHDOG   = 5000;

  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  cnd;
    logic [1:0]  src;
    logic        cin;
    logic [23:0] rd;
    logic [23:0] rs;
    logic [6:0]  i7;
    logic [15:0] i16;
    logic        we;
    logic [23:0] res;
  } vec_t;

  // Incoming flag pattern for table rows: v=1 z=1 n=0.
  localparam vec_t VEC [NVEC] = '{
    '{2'b00, 2'b00, 2'b00, 1'b0, 24'hAB1200, 24'hFF0034, 7'h00, 16'h0000, 1'b1, 24'h001234}, // R2 R7
    '{2'b01, 2'b00, 2'b00, 1'b1, 24'h12F0F0, 24'h77FF00, 7'h00, 16'h0000, 1'b1, 24'h000FF0}, // R3
    '{2'b10, 2'b00, 2'b00, 1'b0, 24'h55AAAA, 24'h0000FF, 7'h00, 16'h0000, 1'b1, 24'h00FF00}, // R4
    '{2'b00, 2'b00, 2'b01, 1'b0, 24'h330001, 24'h000000, 7'h40, 16'h0000, 1'b1, 24'h00FFC1}, // R7 sign
    '{2'b01, 2'b00, 2'b01, 1'b1, 24'h01003F, 24'h000000, 7'h3F, 16'h0000, 1'b1, 24'h000000}, // R7 R9
    '{2'b10, 2'b00, 2'b10, 1'b0, 24'h123456, 24'h000000, 7'h00, 16'hFFFF, 1'b1, 24'h000000}, // R4 R7
    '{2'b00, 2'b00, 2'b10, 1'b1, 24'hFF0001, 24'h000000, 7'h7F, 16'h8000, 1'b1, 24'h008001}, // R7 R1
    '{2'b00, 2'b01, 2'b00, 1'b1, 24'h100010, 24'h000101, 7'h00, 16'h0000, 1'b1, 24'h000111}, // R5
    '{2'b00, 2'b01, 2'b00, 1'b0, 24'h100010, 24'h000101, 7'h00, 16'h0000, 1'b0, 24'h100010}, // R5
    '{2'b01, 2'b10, 2'b00, 1'b0, 24'h00FFFF, 24'h00000F, 7'h00, 16'h0000, 1'b1, 24'h00FFF0}, // R6
    '{2'b01, 2'b10, 2'b00, 1'b1, 24'h00FFFF, 24'h00000F, 7'h00, 16'h0000, 1'b0, 24'h00FFFF}, // R6
    '{2'b10, 2'b01, 2'b00, 1'b0, 24'hABCDEF, 24'h000000, 7'h00, 16'h0000, 1'b0, 24'hABCDEF}, // R5 R10
    '{2'b11, 2'b00, 2'b00, 1'b0, 24'h654321, 24'h00FFFF, 7'h00, 16'h0000, 1'b0, 24'h654321}, // R11
    '{2'b00, 2'b11, 2'b00, 1'b1, 24'h111111, 24'h00FFFF, 7'h00, 16'h0000, 1'b0, 24'h111111}, // R11
    '{2'b00, 2'b00, 2'b11, 1'b0, 24'h222222, 24'h00FFFF, 7'h00, 16'hFFFF, 1'b0, 24'h222222}, // R11
    '{2'b10, 2'b00, 2'b01, 1'b0, 24'hFFFFFF, 24'h000000, 7'h00, 16'h0000, 1'b1, 24'h00FFFF}  // R4 R7
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [1:0]  op_sel, cond_sel, src_sel;
  logic [23:0] rd_val, rs_val;
  logic [6:0]  imm7;
  logic [15:0] imm16;
  logic        flag_c, flag_v, flag_z, flag_n;
  logic        out_valid, wr_en, c_out, v_out, z_out, n_out;
  logic [23:0] rd_new;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_logic_unit u_cond_logic_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .op_sel(op_sel), .cond_sel(cond_sel), .src_sel(src_sel),
    .rd_val(rd_val), .rs_val(rs_val), .imm7(imm7), .imm16(imm16),
    .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z), .flag_n(flag_n),
    .out_valid(out_valid), .wr_en(wr_en), .rd_new(rd_new),
    .c_out(c_out), .v_out(v_out), .z_out(z_out), .n_out(n_out)
  );

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic vld);
    @(negedge clk);
    in_valid = vld;
    op_sel   = v.op;
    cond_sel = v.cnd;
    src_sel  = v.src;
    rd_val   = v.rd;
    rs_val   = v.rs;
    imm7     = v.i7;
    imm16    = v.i16;
    flag_c   = v.cin;
    flag_v   = 1'b1;
    flag_z   = 1'b1;
    flag_n   = 1'b0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    logic [23:0] dest_reg;
    rst = 1'b1; in_valid = 1'b0; op_sel = '0; cond_sel = '0; src_sel = '0;
    rd_val = '0; rs_val = '0; imm7 = '0; imm16 = '0;
    flag_c = 1'b1; flag_v = 1'b1; flag_z = 1'b1; flag_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R13: reset state
    check("R13 valid", {23'b0, out_valid}, 24'h0);
    check("R13 we", {23'b0, wr_en}, 24'h0);
    check("R13 rd", rd_new, 24'h0);
    check("R13 flags", {20'b0, c_out, v_out, z_out, n_out}, 24'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      logic [3:0] exp_f;
      dest_reg = VEC[i].rd;
      drive(VEC[i], 1'b1);
      if (wr_en) dest_reg = rd_new;
      // R12 valid; R5 R6 R10 R11 write-enable; R1-R4 R7 value
      check($sformatf("R12 valid v%0d", i), {23'b0, out_valid}, 24'h1);
      check($sformatf("R5/R6/R11 we v%0d", i), {23'b0, wr_en}, {23'b0, VEC[i].we});
      check($sformatf("R1/R2/R3/R4/R7/R10 dest v%0d", i), dest_reg, VEC[i].res);
      if (VEC[i].we)
        exp_f = {VEC[i].cin, 1'b0, (VEC[i].res[15:0] == 16'h0), VEC[i].res[15]};
      else
        exp_f = {VEC[i].cin, 1'b1, 1'b1, 1'b0};
      // R8 R9 R10 flags {c,v,z,n}
      check($sformatf("R8/R9/R10 flags v%0d", i), {20'b0, c_out, v_out, z_out, n_out},
            {20'b0, exp_f});
    end

    // R12: idle input produces no write even for an executable operation
    drive(VEC[0], 1'b0);
    check("R12 idle valid", {23'b0, out_valid}, 24'h0);
    check("R12 idle we", {23'b0, wr_en}, 24'h0);

    // R12: back-to-back, each result appears exactly one cycle later
    drive(VEC[1], 1'b1);
    check("R12 b2b first", rd_new, 24'h000FF0);
    drive(VEC[2], 1'b1);
    check("R12 b2b second", rd_new, 24'h00FF00);

    // R13: reset after activity clears outputs
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R13 rerun rd", rd_new, 24'h0);
    check("R13 rerun we", {23'b0, wr_en}, 24'h0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule